// File: doc/BRIEF.md
# Accumulator-Style 8-bit Processor Core

This block is a multi-cycle 8-bit processor that executes a compact subset of a well-known handheld-console instruction encoding. Instructions and data live in one byte-wide synchronous memory that sits outside the core. Every opcode is read fresh from that memory, so a program may patch bytes it will execute later.

The core holds an accumulator A, a flag register F and six general registers B, C, D, E, H and L, plus a 16-bit program counter. H and L together form the pointer used for every memory data access. Supported operations are:

- immediate loads;
- register-to-register moves, where one operand slot means "memory at HL";
- eight accumulator ALU operations, in register and immediate forms;
- single-register increment and decrement;
- absolute and conditional jumps;
- a stop instruction that parks the core.

All remaining opcodes are single-byte no-operations. Reset loads the program counter from a start-address input.

Top module: `acc8_core`

## Requirements
- R1: While reset is held, the core drives the start address on `mem_addr`, keeps `mem_we` low and `halted` low; the first opcode fetch after release is from that address.
- R2: Register slot codes are B=0, C=1, D=2, E=3, H=4, L=5, memory-at-HL=6, A=7. Opcode 00rrr110 loads the following byte into slot rrr; for slot 6 (0x36) it writes that byte to address {H,L}.
- R3: Opcode 01dddsss copies slot sss into slot ddd. Slot 6 as source reads memory at {H,L} (e.g. 0x7E), and slot 6 as destination writes memory at {H,L} (e.g. 0x77 stores A, 0x70 stores B). 0x7D copies L into A.
- R4: Opcode 0x76 reads the byte at {H,L} and writes it back to the same address; it does not stop the core.
- R5: Opcodes 10ooosss (register or memory operand) and 11ooo110 (next byte as operand) apply ALU op ooo to A: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP. All ops but CP write A; CP only updates flags.
- R6: F holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, with bits 3..0 zero. ADD and ADC set C on carry out of bit 7. SUB, SBC and CP set C on borrow and set N. AND sets H and clears C. XOR and OR clear H and C. Z is set when the 8-bit result is zero. ADC adds C in, and SBC subtracts C.
- R7: Opcodes 00rrr100 and 00rrr101 (rrr not 6) increment and decrement a register modulo 256. They set Z from the result and leave C unchanged.
- R8: Opcode 0xC3 jumps to the 16-bit address in the next two bytes, low byte first. Opcode 110cc010 jumps only when its condition holds (cc 0 Z clear, 1 Z set, 2 C clear, 3 C set); otherwise execution resumes after the three bytes.
- R9: Opcode 0x10 parks the core. From then on `halted` stays high, `mem_we` stays low and `mem_addr` holds the address one past the stop opcode.
- R10: Every other opcode, including 0x01, 0xCB, 0x34 and 0x35, is a one-byte no-operation that changes neither memory nor registers.
- R11: A byte written to memory is executed as an opcode when the program counter later reaches its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_pc | input | 16 | Program counter value loaded during reset |
| mem_addr | output | 16 | Memory address for read or write |
| mem_wdata | output | 8 | Data to write |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a stop opcode has executed |

## Verification
A wrong register or flag shows up only when a later instruction copies it to memory or bases a jump on it. A corrupted register therefore appears as a wrong data byte on a later `mem_we` cycle, usually within a few instructions. A corrupted flag appears as a store stream that takes the wrong branch, or as a park address different from the expected one. Decode mistakes that change instruction length shift every later fetch. They produce unexpected or missing writes almost at once, and they also move the final `mem_addr` while `halted` is high.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned REG_N  = 8;
  localparam int unsigned SEL_W  = $clog2(REG_N);

  localparam logic [SEL_W-1:0] SLOT_MEM = 3'd6;
  localparam logic [SEL_W-1:0] SLOT_A   = 3'd7;
  localparam logic [SEL_W-1:0] SLOT_H   = 3'd4;
  localparam logic [SEL_W-1:0] SLOT_L   = 3'd5;

  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBC = 3'd3,
                         OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CP  = 3'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_IMM_LO, ST_IMM_HI, ST_MEMRD, ST_EXEC, ST_HALT
  } state_t;

  typedef struct packed { logic z; logic n; logic h; logic c; } flags_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    flags_t            fl;
  } alu_res_t;

  typedef struct packed {
    logic ld_imm;  logic ld_rr;  logic alu_r;  logic alu_imm;
    logic inc;     logic dec;    logic jp;     logic jp_cond;
    logic stop;
    logic [1:0] cc;
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src;
    logic [2:0] aop;
  } dec_t;

  // Accumulator arithmetic and logic; CP returns A unchanged.
  function automatic alu_res_t alu_eval(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input flags_t fin);
    alu_res_t o;
    logic       ci;
    logic [8:0] w;
    logic [4:0] nib;
    logic [7:0] r;
    o   = '0;
    ci  = (op == OP_ADC || op == OP_SBC) ? fin.c : 1'b0;
    w   = '0;
    nib = '0;
    r   = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        w   = {1'b0, a} + {1'b0, b} + {8'd0, ci};
        nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci};
        r = w[7:0]; o.fl.c = w[8]; o.fl.h = nib[4];
      end
      OP_SUB, OP_SBC, OP_CP: begin
        w   = {1'b0, a} - {1'b0, b} - {8'd0, ci};
        nib = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, ci};
        r = w[7:0]; o.fl.c = w[8]; o.fl.h = nib[4]; o.fl.n = 1'b1;
      end
      OP_AND:  begin r = a & b; o.fl.h = 1'b1; end
      OP_XOR:  r = a ^ b;
      default: r = a | b;
    endcase
    o.fl.z = (r == 8'd0);
    o.res  = (op == OP_CP) ? a : r;
    return o;
  endfunction

  // Single-step increment or decrement; carry passes through.
  function automatic alu_res_t step_eval(input logic [7:0] v, input logic down,
                                         input flags_t fin);
    alu_res_t o;
    o.res  = down ? v - 8'd1 : v + 8'd1;
    o.fl.z = (o.res == 8'd0);
    o.fl.n = down;
    o.fl.h = down ? (v[3:0] == 4'h0) : (v[3:0] == 4'hF);
    o.fl.c = fin.c;
    return o;
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode import acc8_pkg::*; (
  input  logic [DATA_W-1:0] op,
  output dec_t              d
);
  always_comb begin
    d     = '0;
    d.dst = op[5:3];
    d.src = op[2:0];
    d.aop = op[5:3];
    d.cc  = op[4:3];
    case (op[7:6])
      2'b00: begin
        if (op == 8'h10)                                   d.stop   = 1'b1;
        else if (op[2:0] == 3'b110)                        d.ld_imm = 1'b1;
        else if (op[2:0] == 3'b100 && op[5:3] != SLOT_MEM) d.inc    = 1'b1;
        else if (op[2:0] == 3'b101 && op[5:3] != SLOT_MEM) d.dec    = 1'b1;
      end
      2'b01: d.ld_rr = 1'b1;
      2'b10: d.alu_r = 1'b1;
      default: begin
        if (op[2:0] == 3'b110) d.alu_imm = 1'b1;
        else if (op == 8'hC3)  d.jp = 1'b1;
        else if (!op[5] && op[2:0] == 3'b010) begin
          d.jp      = 1'b1;
          d.jp_cond = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile import acc8_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [SEL_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  output logic [ADDR_W-1:0] hl,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] q [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_slot
    if (i == int'(SLOT_MEM)) begin : g_hole
      assign q[i] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else if (we && waddr == SEL_W'(i)) r <= wdata;
      end
      assign q[i] = r;
    end
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
  assign hl      = {q[SLOT_H], q[SLOT_L]};
  assign acc     = q[SLOT_A];

  assert_no_hole_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> waddr != SLOT_MEM);
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu import acc8_pkg::*; (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] v,
  input  logic              step,
  input  logic              down,
  input  flags_t            fin,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);
  alu_res_t o;
  always_comb o = step ? step_eval(v, down, fin) : alu_eval(op, a, b, fin);
  assign res  = o.res;
  assign fout = o.fl;
endmodule

// File: rtl/acc8_core.sv
module acc8_core import acc8_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_pc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  state_t            state, state_nx;
  logic [ADDR_W-1:0] pc, pc_nx, hl, jump_target;
  logic [DATA_W-1:0] ir, tmp, op_now, src_val, dst_val, acc, operand, alu_res, rf_wdata;
  logic [SEL_W-1:0]  rf_waddr;
  flags_t            flg, alu_fl;
  dec_t              d;
  logic needs_imm, src_mem, dst_mem, step, cond_ok, in_exec, rf_we;
  logic ev_store, ev_alu, ev_incdec, ev_load, ev_jump;

  assign op_now = (state == ST_DECODE) ? mem_rdata : ir;
  acc8_decode u_dec (.op(op_now), .d(d));

  assign needs_imm = d.ld_imm | d.alu_imm | d.jp;
  assign src_mem   = (d.ld_rr | d.alu_r) && d.src == SLOT_MEM;
  assign dst_mem   = (d.ld_imm | d.ld_rr) && d.dst == SLOT_MEM;
  assign step      = d.inc | d.dec;
  assign operand   = (src_mem || needs_imm) ? tmp : src_val;

  always_comb begin
    case (d.cc)
      2'd0:    cond_ok = !flg.z;
      2'd1:    cond_ok =  flg.z;
      2'd2:    cond_ok = !flg.c;
      default: cond_ok =  flg.c;
    endcase
  end

  // Named events for the checks below
  assign in_exec     = (state == ST_EXEC);
  assign ev_store    = in_exec && dst_mem;
  assign ev_alu      = in_exec && (d.alu_r | d.alu_imm);
  assign ev_incdec   = in_exec && step;
  assign ev_load     = in_exec && (d.ld_imm | d.ld_rr) && !dst_mem;
  assign ev_jump     = (state == ST_IMM_HI) && (!d.jp_cond || cond_ok);
  assign jump_target = {mem_rdata, tmp};

  assign rf_we    = ev_load | ev_incdec | (ev_alu && d.aop != OP_CP);
  assign rf_waddr = ev_alu ? SLOT_A : d.dst;
  assign rf_wdata = ev_load ? operand : alu_res;

  acc8_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(d.src), .rdata_a(src_val), .raddr_b(d.dst), .rdata_b(dst_val),
    .hl(hl), .acc(acc));

  acc8_alu u_alu (
    .op(d.aop), .a(acc), .b(operand), .v(dst_val), .step(step), .down(d.dec),
    .fin(flg), .res(alu_res), .fout(alu_fl));

  assign mem_we    = ev_store;
  assign mem_wdata = operand;
  assign halted    = (state == ST_HALT);

  always_comb begin
    mem_addr = pc;
    if ((state == ST_DECODE && src_mem) || ev_store) mem_addr = hl;
  end

  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    case (state)
      ST_FETCH: begin pc_nx = pc + 1'b1; state_nx = ST_DECODE; end
      ST_DECODE: begin
        if (d.stop) state_nx = ST_HALT;
        else if (needs_imm) begin pc_nx = pc + 1'b1; state_nx = ST_IMM_LO; end
        else if (src_mem) state_nx = ST_MEMRD;
        else if (d.ld_rr | d.alu_r | step) state_nx = ST_EXEC;
        else state_nx = ST_FETCH;
      end
      ST_IMM_LO: begin
        if (d.jp) begin pc_nx = pc + 1'b1; state_nx = ST_IMM_HI; end
        else state_nx = ST_EXEC;
      end
      ST_IMM_HI: begin
        if (ev_jump) pc_nx = jump_target;
        state_nx = ST_FETCH;
      end
      ST_MEMRD: state_nx = ST_EXEC;
      ST_EXEC:  state_nx = ST_FETCH;
      default:  state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= start_pc;
      ir    <= '0;
      tmp   <= '0;
      flg   <= '0;
    end else begin
      state <= state_nx;
      pc    <= pc_nx;
      if (state == ST_DECODE) ir <= mem_rdata;
      if (state == ST_IMM_LO || state == ST_MEMRD) tmp <= mem_rdata;
      if (ev_alu || ev_incdec) flg <= alu_fl;
    end
  end

  assert_store_at_hl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == hl);
  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr));
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  assert_cp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alu && d.aop == OP_CP) |=> $stable(acc));
  assert_step_keeps_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incdec |=> $stable(flg.c));
  assert_and_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alu && d.aop == OP_AND) |=> flg.h && !flg.n && !flg.c);
  assert_jump_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> mem_addr == $past(jump_target));
endmodule

// File: tb/acc8_core_test.sv
module acc8_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] start_pc = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halted;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  acc8_core uut (.clk(clk), .rst_n(rst_n), .start_pc(start_pc), .mem_addr(mem_addr),
                 .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
                 .halted(halted));

  logic [7:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  typedef struct { logic [15:0] a; logic [7:0] d; string req; } wr_t;
  wr_t sbq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [15:0] a, input logic [7:0] v, input string req);
    wr_t e;
    e.a = a; e.d = v; e.req = req;
    sbq.push_back(e);
  endtask

  // Monitor: each write the core issues must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (sbq.size() == 0) chk(1'b0, "unexpected write R10", {8'd0, mem_addr, mem_wdata}, 32'd0);
      else begin
        wr_t e;
        e = sbq.pop_front();
        chk(mem_addr == e.a && mem_wdata == e.d, e.req,
            {8'd0, mem_addr, mem_wdata}, {8'd0, e.a, e.d});
      end
    end
  end

  task automatic load(input logic [15:0] base, input logic [7:0] code[]);
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    foreach (code[i]) mem[base[11:0] + 12'(i)] = code[i];
  endtask

  task automatic run_prog(input logic [15:0] start, input logic [15:0] park, input string req);
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    start_pc = start;
    repeat (2) @(negedge clk);
    chk(mem_addr == start && !halted && !mem_we, "R1 reset fetch address",
        {15'd0, halted, mem_addr}, {16'd0, start});
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    chk(halted, {req, " R9 reached stop"}, 32'(n), 32'd0);
    repeat (3) @(negedge clk);
    chk(halted && mem_addr == park, {req, " R9 park address"}, {15'd0, halted, mem_addr},
        {15'd0, 1'b1, park});
    chk(sbq.size() == 0, {req, " missing writes"}, 32'(sbq.size()), 32'd0);
    sbq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] p[];
    // Loads, moves and a patched opcode (R2 R3 R11)
    p = '{8'h26,8'h02, 8'h2E,8'h00, 8'h3E,8'h69, 8'h77, 8'h06,8'hA5, 8'h2C, 8'h70,
          8'h26,8'h01, 8'h2E,8'h13, 8'h36,8'hEE, 8'h00, 8'h00, 8'h10, 8'h0F,
          8'h26,8'h02, 8'h2E,8'h02, 8'h77, 8'h7E, 8'h2C, 8'h7D, 8'h77, 8'h10, 8'h00};
    load(16'h0100, p);
    expect_wr(16'h0200, 8'h69, "R3 store A");
    expect_wr(16'h0201, 8'hA5, "R2 R3 load B then store");
    expect_wr(16'h0113, 8'hEE, "R2 immediate to HL");
    expect_wr(16'h0202, 8'h66, "R11 patched XOR executed");
    expect_wr(16'h0203, 8'h03, "R3 L to A");
    run_prog(16'h0100, 16'h011F, "P1");

    // Decrementing store loop (R7 R8)
    p = '{8'h26,8'h03, 8'h2E,8'h10, 8'h3E,8'h04, 8'h77, 8'h2C, 8'h3D, 8'hFE,8'h00,
          8'hC2,8'h06,8'h00, 8'h10, 8'h00};
    load(16'h0000, p);
    for (int k = 0; k < 4; k++) expect_wr(16'h0310 + 16'(k), 8'(4 - k), "R7 R8 loop value");
    run_prog(16'h0000, 16'h000F, "P2");

    // ALU ops, carries and conditional jumps (R5 R6 R8)
    p = '{8'h26,8'h05, 8'h2E,8'h00, 8'h3E,8'hF0, 8'hC6,8'h20, 8'h77, 8'h2C,
          8'hCE,8'h05, 8'h77, 8'h2C, 8'hD6,8'h20, 8'h77, 8'h2C, 8'hDE,8'h06, 8'h77, 8'h2C,
          8'hE6,8'h3C, 8'h77, 8'h2C, 8'hF6,8'h81, 8'h77, 8'h2C, 8'h0E,8'h5A, 8'hA9, 8'h77, 8'h2C,
          8'hB9, 8'hDA,8'h00,8'h00, 8'hCA,8'h00,8'h00, 8'h77, 8'h2C, 8'hFE,8'hF7,
          8'hCA,8'h33,8'h04, 8'h77, 8'h00, 8'h06,8'h07, 8'h80, 8'h87,
          8'hD2,8'h00,8'h00, 8'hDA,8'h3E,8'h04, 8'h10, 8'h77, 8'h91, 8'h3C, 8'h2C, 8'h77,
          8'h10, 8'h00};
    load(16'h0400, p);
    expect_wr(16'h0500, 8'h10, "R5 ADD imm");
    expect_wr(16'h0501, 8'h16, "R6 ADC folds carry");
    expect_wr(16'h0502, 8'hF6, "R5 SUB imm");
    expect_wr(16'h0503, 8'hEF, "R6 SBC folds borrow");
    expect_wr(16'h0504, 8'h2C, "R5 AND imm");
    expect_wr(16'h0505, 8'hAD, "R5 OR imm");
    expect_wr(16'h0506, 8'hF7, "R5 XOR reg");
    expect_wr(16'h0507, 8'hF7, "R5 CP keeps A, R8 not taken");
    expect_wr(16'h0508, 8'hFC, "R6 carry jump taken");
    expect_wr(16'h0509, 8'hA3, "R5 SUB reg then INC");
    run_prog(16'h0400, 16'h0444, "P3");

    // Unsupported opcodes, 0x76, other INC/DEC (R4 R10 R7)
    p = '{8'h26,8'h07, 8'h2E,8'h00, 8'h01, 8'h3E,8'h11, 8'hCB, 8'h36,8'h42, 8'h76, 8'h86,
          8'h16,8'hFF, 8'h14, 8'hC2,8'h00,8'h00, 8'h2C, 8'h72, 8'h1D, 8'h2C, 8'h73,
          8'h2C, 8'h77, 8'h34, 8'h10, 8'h00};
    load(16'h0600, p);
    expect_wr(16'h0700, 8'h42, "R2 immediate to HL");
    expect_wr(16'h0700, 8'h42, "R4 write back");
    expect_wr(16'h0701, 8'h00, "R7 INC wraps, sets Z");
    expect_wr(16'h0702, 8'hFF, "R7 DEC wraps");
    expect_wr(16'h0703, 8'h53, "R10 one-byte NOP then ADD (HL)");
    run_prog(16'h0600, 16'h061B, "P4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule